// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block executes commands on a serial NOR flash bus of up to eight data lanes. Software fills a bank of command words and writes word 0 last, which launches the command. An instruction carries the opcode, up to six address bytes, the lane widths and the target bank. It either runs at once (type 0) or is held until a data descriptor (type 127) follows (type 1). The descriptor supplies the byte count, the dummy clock count, the data lane width and the direction.

Read data lands in a small byte buffer that the host reads afterwards. Write data is taken from the same buffer, which the host fills before the descriptor is launched. The serial clock runs at half the system clock, in SPI mode 0. Completion and error status are held until the next launch, and so are three interrupt flags: done, data ready and data error.

Top module: `flash_cmd_seq`

## Requirements
- R1: A write to word index 0 while `busy` is 0 launches the command held in words 1..4. While `busy` is 1, writes to any command word are ignored. A held type 1 instruction does not set `busy` and produces no bus activity.
- R2: The instruction type is word 1 bits 6:0. Type 0 shifts out the opcode and the address, then completes with `cmd_status` = 16'h8000 (bit 15 completed, bit 14 failed).
- R3: The opcode is word 3 bits 23:16 and the address byte count is word 3 bits 30:28. Address byte 0 is word 1 bits 31:24, bytes 1..4 are word 2 from the low byte up, and byte 5 is word 3 bits 7:0. The opcode goes out first, then the address bytes from the highest byte down to byte 0, each MSB first.
- R4: Lane codes are 0/1/2/3 for 1/2/4/8 lanes. The address code is word 4 bits 1:0, the command code is word 4 bits 9:8, and the data code is descriptor word 4 bits 9:8. On N lanes each clock carries N bits, with the earliest bit on the highest lane. A single-lane transfer drives lane 0 and samples lane 1.
- R5: Word 4 bits 14:12 select the bank. Only `fl_cs_n[bank]` is driven low, and it stays low from the first opcode clock through the last data clock.
- R6: The descriptor byte count is {word 3 bits 15:0, word 2 bits 31:16}, and the dummy clock count is word 3 bits 25:20. During dummy clocks no lane is driven.
- R7: Descriptor word 4 bit 4 sets the direction. 0 reads from flash into buffer bytes 0 upward. 1 writes buffer bytes 0 upward to flash, driving the data lanes.
- R8: A type 127 descriptor with no held type 1, any other type after a held type 1, an unknown type, or an address count of 7 produces no bus activity. Each completes with `cmd_status` = 16'hC001 (invalid sequence in bit 0).
- R9: A descriptor byte count above BUF_BYTES produces no bus activity, completes with `cmd_status` = 16'hC002 (bus error in bit 1), and sets `irq_data_err`.
- R10: On completion, `irq_done` is set if word 0 bit 0 was 1 at launch. `irq_data_req` is set after a read with a nonzero count. Every accepted launch clears all flags and `cmd_status`.
- R11: After reset all chip selects are high, `fl_sck` is low, no lane is driven, and `busy`, `cmd_status` and all flags are 0.
- R12: SPI mode 0 timing: `fl_sck` is low when idle, and the driven lanes change only while `fl_sck` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Command word write strobe |
| reg_idx | input | 3 | Command word index 0..5 |
| reg_wdata | input | 32 | Command word write data |
| hb_we | input | 1 | Host buffer byte write strobe |
| hb_addr | input | $clog2(BUF_BYTES) | Host buffer byte address |
| hb_wdata | input | 8 | Host buffer write byte |
| hb_rdata | output | 8 | Host buffer read byte |
| busy | output | 1 | Engine running a bus transfer |
| cmd_status | output | 16 | Completion and error status |
| irq_done | output | 1 | Command done flag |
| irq_data_req | output | 1 | Read data ready in buffer |
| irq_data_err | output | 1 | Data transfer error flag |
| fl_cs_n | output | NBANK | Per-bank chip selects, active low |
| fl_sck | output | 1 | Serial clock |
| fl_dq_o | output | 8 | Lane output values |
| fl_dq_oe | output | 8 | Lane output enables |
| fl_dq_i | input | 8 | Lane input values |

## Verification
The bench goes after the places where lane widths meet byte boundaries. A sequencer with a wrong bit order, lane mapping or byte count would put misaligned bytes on the bus. A single-lane read that sampled lane 0 instead of lane 1 would fill the buffer with wrong bytes. It checks that dummy clocks drive no lanes, and that the address goes out from its top byte down. A design that ignored the command split would run a held instruction on its own or accept a stray descriptor, and would then show bus clocks where none are allowed. The bench also launches while busy and leaves a bad word in the bank. A design that let these through would restart the transfer or run a corrupted command.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int NBANK     = 8,
  parameter int BUF_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [2:0]                   reg_idx,
  input  logic [31:0]                  reg_wdata,
  input  logic                         hb_we,
  input  logic [$clog2(BUF_BYTES)-1:0] hb_addr,
  input  logic [7:0]                   hb_wdata,
  output logic [7:0]                   hb_rdata,
  output logic                         busy,
  output logic [15:0]                  cmd_status,
  output logic                         irq_done,
  output logic                         irq_data_req,
  output logic                         irq_data_err,
  output logic [NBANK-1:0]             fl_cs_n,
  output logic                         fl_sck,
  output logic [7:0]                   fl_dq_o,
  output logic [7:0]                   fl_dq_oe,
  input  logic [7:0]                   fl_dq_i
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int CW = $clog2(BUF_BYTES + 64) + 1;

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_OPC, S_ADR, S_DUM, S_DAT, S_FIN} st_t;
  st_t st;

  logic [31:0] w1, w2, w3, w4;
  logic [7:0]  opc, sh, rx;
  logic [47:0] adr;
  logic [2:0]  nab, bank, beat;
  logic [1:0]  clc, alc, dlc, lc;
  logic [5:0]  ndum;
  logic [CW-1:0] cnt, dlen;
  logic        half, dir_wr, done_req, rd_seq;
  logic [15:0] fin_stat;
  logic [7:0]  mem [BUF_BYTES];

  logic [6:0]  ty;
  logic [31:0] dcount;
  logic        trig, drive;
  logic [3:0]  lanes;
  logic [7:0]  lmask, in_bits;
  logic [2:0]  last;

  assign ty      = w1[6:0];
  assign dcount  = {w3[15:0], w2[31:16]};
  assign busy    = !(st == S_IDLE || st == S_PEND);
  assign trig    = reg_we && reg_idx == 3'd0 && !busy;
  assign lanes   = 4'd1 << lc;
  assign lmask   = ~(8'hFF << lanes);
  assign last    = 3'((4'd8 >> lc) - 4'd1);
  assign in_bits = (lc == 2'd0) ? {7'd0, fl_dq_i[1]} : (fl_dq_i & lmask);
  assign drive   = st == S_OPC || st == S_ADR || (st == S_DAT && dir_wr);
  assign fl_dq_oe = drive ? lmask : 8'd0;
  assign fl_dq_o  = !drive ? 8'd0 :
                    (lc == 2'd0) ? {7'd0, sh[7]} : ((sh >> (4'd8 - lanes)) & lmask);
  assign hb_rdata = mem[hb_addr];

  for (genvar i = 0; i < NBANK; i++) begin : g_cs
    assign fl_cs_n[i] = !((st == S_OPC || st == S_ADR || st == S_DUM || st == S_DAT) &&
                          bank == 3'(i));
  end

  function automatic logic [7:0] abyte(input logic [2:0] i);
    return adr[8*i +: 8];
  endfunction

  always_ff @(posedge clk) begin
    if (hb_we && !busy)
      mem[hb_addr] <= hb_wdata;
    else if (st == S_DAT && half && beat == last && !dir_wr)
      mem[cnt[AW-1:0]] <= rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; w1 <= '0; w2 <= '0; w3 <= '0; w4 <= '0;
      opc <= '0; sh <= '0; rx <= '0; adr <= '0; nab <= '0; bank <= '0; beat <= '0;
      clc <= '0; alc <= '0; dlc <= '0; lc <= '0; ndum <= '0; cnt <= '0; dlen <= '0;
      half <= 1'b0; dir_wr <= 1'b0; done_req <= 1'b0; rd_seq <= 1'b0; fin_stat <= '0;
      cmd_status <= '0; irq_done <= 1'b0; irq_data_req <= 1'b0; irq_data_err <= 1'b0;
      fl_sck <= 1'b0;
    end else if (reg_we && !busy && reg_idx != 3'd0) begin
      case (reg_idx)
        3'd1: w1 <= reg_wdata;
        3'd2: w2 <= reg_wdata;
        3'd3: w3 <= reg_wdata;
        3'd4: w4 <= reg_wdata;
        default: ;
      endcase
    end else if (trig) begin
      cmd_status <= '0; irq_done <= 1'b0; irq_data_req <= 1'b0; irq_data_err <= 1'b0;
      done_req <= reg_wdata[0]; fin_stat <= 16'h8000; beat <= '0; half <= 1'b0;
      if ((ty == 7'd0 || ty == 7'd1) && st != S_PEND && w3[30:28] != 3'd7) begin
        opc <= w3[23:16]; adr <= {w3[7:0], w2, w1[31:24]}; nab <= w3[30:28];
        clc <= w4[9:8]; alc <= w4[1:0]; bank <= w4[14:12];
        ndum <= '0; dlen <= '0; rd_seq <= 1'b0;
        if (ty == 7'd0) begin
          st <= S_OPC; sh <= w3[23:16]; lc <= w4[9:8];
        end else
          st <= S_PEND;
      end else if (ty == 7'd127 && st == S_PEND) begin
        if (dcount > 32'(BUF_BYTES)) begin
          st <= S_FIN; fin_stat <= 16'hC002; irq_data_err <= 1'b1;
        end else begin
          dlen <= dcount[CW-1:0]; ndum <= w3[25:20]; dlc <= w4[9:8]; dir_wr <= w4[4];
          rd_seq <= !w4[4] && dcount != 0;
          st <= S_OPC; sh <= opc; lc <= clc;
        end
      end else begin
        st <= S_FIN; fin_stat <= 16'hC001;
      end
    end else if (st == S_FIN) begin
      st <= S_IDLE; cmd_status <= fin_stat; irq_done <= done_req;
      irq_data_req <= rd_seq && !fin_stat[14];
    end else if (busy) begin
      if (!half) begin
        fl_sck <= 1'b1; half <= 1'b1; rx <= (rx << lanes) | in_bits;
      end else begin
        fl_sck <= 1'b0; half <= 1'b0; beat <= beat + 3'd1; sh <= sh << lanes;
        if (beat == last) begin
          beat <= '0;
          case (st)
            S_OPC, S_ADR:
              if ((st == S_OPC && nab == 3'd0) || (st == S_ADR && cnt == '0)) begin
                if (ndum != 6'd0) begin
                  st <= S_DUM; cnt <= CW'(ndum); lc <= 2'd3;
                end else if (dlen != '0) begin
                  st <= S_DAT; cnt <= '0; lc <= dlc; sh <= mem[0];
                end else
                  st <= S_FIN;
              end else if (st == S_OPC) begin
                st <= S_ADR; cnt <= CW'(nab - 3'd1); sh <= abyte(nab - 3'd1); lc <= alc;
              end else begin
                cnt <= cnt - 1'b1; sh <= abyte(cnt[2:0] - 3'd1);
              end
            S_DUM:
              if (cnt == CW'(1)) begin
                if (dlen != '0) begin
                  st <= S_DAT; cnt <= '0; lc <= dlc; sh <= mem[0];
                end else
                  st <= S_FIN;
              end else
                cnt <= cnt - 1'b1;
            S_DAT:
              if (cnt == dlen - 1'b1)
                st <= S_FIN;
              else begin
                cnt <= cnt + 1'b1; sh <= mem[AW'(cnt + 1'b1)];
              end
            default: ;
          endcase
        end
      end
    end
  end

  a_r5_one_cs: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~fl_cs_n));
  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&fl_cs_n && !fl_sck && fl_dq_oe == 8'd0));
  a_r12_dq_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fl_dq_o) |-> !fl_sck);
  a_r8_fail_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_status[14] |-> (cmd_status[15] && (|cmd_status[1:0])));
  a_r10_dreq_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
    irq_data_req |-> (cmd_status[15] && !cmd_status[14]));
  a_r1_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd_status == 16'd0 && !irq_done));
endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int CLK_P = 10;
  localparam int NB = 8;
  localparam int BB = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, hb_we = 1'b0;
  logic [2:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0] hb_addr = '0;
  logic [7:0] hb_wdata = '0, hb_rdata;
  logic busy, irq_done, irq_data_req, irq_data_err, fl_sck;
  logic [15:0] cmd_status;
  logic [NB-1:0] fl_cs_n;
  logic [7:0] fl_dq_o, fl_dq_oe, fl_dq_i;

  int checks = 0, fails = 0, nb = 0;
  logic [7:0] log_o [512];
  logic [7:0] log_oe [512];
  logic [7:0] log_cs [512];

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_seq #(.NBANK(NB), .BUF_BYTES(BB)) u0 (
    .clk, .rst_n, .reg_we, .reg_idx, .reg_wdata, .hb_we, .hb_addr, .hb_wdata, .hb_rdata,
    .busy, .cmd_status, .irq_done, .irq_data_req, .irq_data_err,
    .fl_cs_n, .fl_sck, .fl_dq_o, .fl_dq_oe, .fl_dq_i);

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 29 + 90);
  endfunction

  assign fl_dq_i = pat(nb);

  always @(posedge fl_sck) begin
    log_o[nb] = fl_dq_o; log_oe[nb] = fl_dq_oe; log_cs[nb] = fl_cs_n; nb = nb + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sent(input int s, input int l);
    logic [7:0] v = '0;
    for (int b = 0; b < 8 / l; b++)
      v = (v << l) | ((l == 1) ? {7'd0, log_o[s+b][0]} : (log_o[s+b] & 8'((1 << l) - 1)));
    return v;
  endfunction

  function automatic logic [7:0] rexp(input int s, input int l);
    logic [7:0] v = '0;
    for (int b = 0; b < 8 / l; b++)
      v = (v << l) | ((l == 1) ? {7'd0, pat(s+b)[1]} : (pat(s+b) & 8'((1 << l) - 1)));
    return v;
  endfunction

  task automatic wreg(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic hwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); hb_we = 1'b1; hb_addr = a; hb_wdata = d;
    @(negedge clk); hb_we = 1'b0;
  endtask

  task automatic launch(input logic [31:0] x1, x2, x3, x4, x0);
    nb = 0;
    wreg(5, 0); wreg(4, x4); wreg(3, x3); wreg(2, x2); wreg(1, x1); wreg(0, x0);
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] ca3(input logic [2:0] n, input logic [7:0] op, input logic [7:0] a5);
    return {1'b0, n, 4'd0, op, 8'd0, a5};
  endfunction
  function automatic logic [31:0] ca4(input logic [2:0] bk, input logic [1:0] c, input logic [1:0] a);
    return {17'd0, bk, 2'd0, c, 6'd0, a};
  endfunction
  function automatic logic [31:0] ds3(input logic [5:0] dm, input logic [15:0] hi);
    return {6'd0, dm, 4'd0, hi};
  endfunction
  function automatic logic [31:0] ds4(input logic [2:0] bk, input logic [1:0] d, input logic dr);
    return {17'd0, bk, 2'd0, d, 3'd0, dr, 4'd0};
  endfunction

  task automatic t_reset;
    chk("R11 busy", busy, 0);
    chk("R11 cs", fl_cs_n, 8'hFF);
    chk("R11 sck/oe", {fl_sck, fl_dq_oe}, 0);
    chk("R11 status/flags", {cmd_status, irq_done, irq_data_req, irq_data_err}, 0);
  endtask

  task automatic t_cmd_only;
    bit ok = 1;
    launch(0, 0, ca3(0, 8'h06, 0), ca4(2, 0, 0), 1);
    wait_idle;
    chk("R2 beats", nb, 8);
    chk("R2 opcode", sent(0, 1), 8'h06);
    for (int k = 0; k < 8; k++) if (log_cs[k] !== 8'hFB) ok = 0;
    chk("R5 bank cs", ok, 1);
    chk("R2 status", cmd_status, 16'h8000);
    chk("R10 done flag", irq_done, 1);
    chk("R12 sck idle", fl_sck, 0);
  endtask

  task automatic t_addr_quad;
    launch({8'h56, 24'd0}, 32'h0000_1234, ca3(3, 8'h20, 0), ca4(0, 0, 2), 0);
    wait_idle;
    chk("R4 quad addr beats", nb, 14);
    chk("R3 opcode", sent(0, 1), 8'h20);
    chk("R3 addr hi", sent(8, 4), 8'h12);
    chk("R3 addr mid", sent(10, 4), 8'h34);
    chk("R3 addr lo", sent(12, 4), 8'h56);
    chk("R4 quad oe", log_oe[9], 8'h0F);
    chk("R10 no done", irq_done, 0);
  endtask

  task automatic t_octal;
    launch(0, 0, ca3(0, 8'hA5, 0), ca4(1, 3, 0), 0);
    wait_idle;
    chk("R4 octal beats", nb, 1);
    chk("R4 octal value", {log_o[0], log_oe[0]}, {8'hA5, 8'hFF});
  endtask

  task automatic t_read_quad;
    bit ok = 1;
    launch({8'hEF, 24'd1}, 32'h0000_ABCD, ca3(3, 8'h6B, 0), ca4(0, 0, 0), 0);
    @(negedge clk);
    chk("R1 held type1 not busy", busy, 0);
    chk("R1 held type1 no bus", nb, 0);
    launch(32'd127, {16'd4, 16'd0}, ds3(8, 0), ds4(0, 2, 0), 1);
    wait_idle;
    chk("R6 read beats", nb, 48);
    chk("R3 addr order", {sent(8, 1), sent(16, 1), sent(24, 1)}, 24'hABCDEF);
    for (int k = 32; k < 48; k++) if (log_oe[k] !== 8'd0) ok = 0;
    chk("R6 dummy and read undriven", ok, 1);
    for (int j = 0; j < 4; j++) begin
      hb_addr = 4'(j); #1;
      chk("R7 read byte", hb_rdata, rexp(40 + 2 * j, 4));
    end
    chk("R10 read flags", {cmd_status, irq_done, irq_data_req}, {16'h8000, 2'b11});
  endtask

  task automatic t_read_single;
    launch(32'd1, 0, ca3(0, 8'h03, 0), ca4(3, 0, 0), 0);
    @(negedge clk);
    chk("R10 flags cleared on launch", {irq_data_req, irq_done, cmd_status}, 0);
    launch(32'd127, {16'd2, 16'd0}, ds3(0, 0), ds4(3, 0, 0), 0);
    wait_idle;
    chk("R4 x1 read beats", nb, 24);
    hb_addr = 0; #1; chk("R4 x1 read lane1 b0", hb_rdata, rexp(8, 1));
    hb_addr = 1; #1; chk("R4 x1 read lane1 b1", hb_rdata, rexp(16, 1));
    chk("R5 cs bank3", log_cs[20], 8'hF7);
  endtask

  task automatic t_write_dual;
    logic [7:0] d [5] = '{8'h11, 8'h22, 8'h9C, 8'h47, 8'hE8};
    for (int j = 0; j < 5; j++) hwr(4'(j), d[j]);
    launch({8'h00, 24'd1}, 32'h0000_0001, ca3(3, 8'h02, 0), ca4(1, 0, 0), 0);
    launch(32'd127, {16'd5, 16'd0}, ds3(0, 0), ds4(1, 1, 1), 0);
    wait_idle;
    chk("R7 write beats", nb, 52);
    for (int j = 0; j < 5; j++) chk("R7 write byte", sent(32 + 4 * j, 2), d[j]);
    chk("R7 write oe", log_oe[33], 8'h03);
    chk("R7 status", cmd_status, 16'h8000);
    chk("R10 no data req on write", irq_data_req, 0);
  endtask

  task automatic t_invalid;
    launch(32'd127, {16'd1, 16'd0}, 0, 0, 1);
    wait_idle;
    chk("R8 stray descriptor", {cmd_status, irq_done}, {16'hC001, 1'b1});
    chk("R8 stray no bus", nb, 0);
    launch(32'd1, 0, ca3(1, 8'h0B, 0), 0, 0);
    launch(32'd0, 0, ca3(1, 8'h0B, 0), 0, 0);
    wait_idle;
    chk("R8 type1 then type0", cmd_status, 16'hC001);
    chk("R8 no bus", nb, 0);
    launch(32'd9, 0, 0, 0, 0);
    wait_idle;
    chk("R8 unknown type", cmd_status, 16'hC001);
  endtask

  task automatic t_toolong;
    launch(32'd1, 0, ca3(0, 8'h03, 0), 0, 0);
    launch(32'd127, {16'd17, 16'd0}, 0, 0, 0);
    wait_idle;
    chk("R9 long count", {cmd_status, irq_data_err}, {16'hC002, 1'b1});
    chk("R9 no bus", nb, 0);
    launch(32'd1, 0, ca3(0, 8'h03, 0), 0, 0);
    launch(32'd127, 32'd0, ds3(0, 16'd1), 0, 0);
    wait_idle;
    chk("R9 high half count", cmd_status, 16'hC002);
  endtask

  task automatic t_busy;
    launch({8'h01, 24'd0}, 32'h0504_0302, ca3(6, 8'h9F, 8'h06), 0, 0);
    chk("R1 busy during transfer", busy, 1);
    wreg(1, 32'd127);
    wreg(0, 32'd1);
    wait_idle;
    chk("R1 ignored relaunch beats", nb, 56);
    chk("R1 ignored relaunch done", irq_done, 0);
    chk("R3 six addr first", sent(8, 1), 8'h06);
    chk("R3 six addr last", sent(48, 1), 8'h01);
    nb = 0;
    wreg(0, 0);
    wait_idle;
    chk("R1 word1 write while busy ignored", {cmd_status, 16'(nb)}, {16'h8000, 16'd56});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog act=%h exp=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_cmd_only;
    t_addr_quad;
    t_octal;
    t_read_quad;
    t_read_single;
    t_write_dual;
    t_invalid;
    t_toolong;
    t_busy;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule